// File: doc/BRIEF.md
# SPI Slave with Double-Buffered Transmit

This block is a byte-wide SPI slave. It runs on a fast system clock and oversamples the external serial clock, data-in and select lines. It works in SPI mode 0: the serial clock idles low, incoming data is sampled on the rising edge, outgoing data changes on the falling edge, and bytes travel most significant bit first. The slave never starts a transfer. Every bit it moves is paced by the master's serial clock.

Host logic talks to the slave through a small register-style interface. A write puts a byte in a transmit holding buffer. The byte moves into the transmit shift register at once if that register is empty. Otherwise it waits there until the current byte on the wire has finished. Received bytes are copied into a receive buffer that the host reads. A completion flag marks each finished byte and stays set until the host clears it. An enable input and a wiring-mode input complete the interface. With the mode input low, the chip-select line gates the slave (4-wire). With it high, chip-select is ignored and the slave is always selected (3-wire).

Top module: `spi_slave_dbuf`

## Requirements
- R1: Bits on `spi_mosi` are captured on rising edges of `spi_sck`, first bit as bit 7. After eight captured bits the whole byte appears on `host_rdata`.
- R2: `xfer_done` goes to 1 after the eighth rising edge of a byte. It stays at 1 until a cycle with `xfer_done_clr` high. If a clear and a new byte end arrive in the same cycle, the flag stays set.
- R3: `spi_miso` shows bit 7 of the transmit byte before the first rising edge of a byte. It moves to the next lower bit after each following falling edge, so the master receives the byte MSB first.
- R4: A host write while the transmit shift register is empty loads that register at once, and the next byte on the wire carries the written value.
- R5: A host write while the shift register is loaded goes into the holding buffer. The buffer is moved into the shift register when the byte in progress ends. A later write before that moment replaces the buffered value.
- R6: When no data is waiting in the shift register, the slave sends 0x00.
- R7: In 4-wire mode with `spi_nss` high, `spi_miso_oe` is 0 and `spi_miso` is released to high impedance. Serial clock edges are not counted, so `host_rdata` and `xfer_done` do not change.
- R8: In 4-wire mode a falling edge on `spi_nss` clears the bit counter and drops any partly received byte.
- R9: In 3-wire mode (`cfg_three_wire` = 1) `spi_nss` is ignored. The slave drives `spi_miso_oe` whenever it is enabled, and edges on `spi_nss` do not reset the bit counter.
- R10: With `cfg_en` low the bit counter, shift register and holding buffer are all cleared, host writes are dropped, and `spi_miso_oe` is 0. Setting `cfg_en` low and then high again is the way to resynchronise the counter in 3-wire mode.
- R11: After reset `host_rdata` is 0x00 and both `xfer_done` and `spi_miso_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Slave enable; low clears the transfer state |
| cfg_three_wire | input | 1 | 1 = chip-select ignored, 0 = chip-select gates the slave |
| host_wr | input | 1 | One-cycle write strobe for transmit data |
| host_wdata | input | 8 | Transmit byte |
| host_rdata | output | 8 | Last complete received byte |
| xfer_done | output | 1 | Byte-complete flag |
| xfer_done_clr | input | 1 | Clears the byte-complete flag |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_nss | input | 1 | Active-low chip-select |
| spi_miso | output | 1 | Serial data to the master, high impedance when not driven |
| spi_miso_oe | output | 1 | Output enable for spi_miso |

## Verification
Some invariants hold on every cycle, and the embedded assertions check these:
- an empty shift register always holds zeros;
- the holding buffer is never occupied while the shift register is empty;
- the counter stays put between qualified serial clock edges and is cleared by disable;
- the flag follows every final bit;
- a deselected slave never changes its receive buffer.

Other behaviour depends on whole sequences of serial traffic, so only the bench scenarios can show it:
- the exact bit order on MISO;
- which buffered byte the master sees in which transfer, including a replaced buffer;
- the 3-wire case where a chip-select toggle must not realign a split byte;
- the enable toggle that does realign it.

// File: rtl/spis_pkg.sv
package spis_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef enum logic {
        SEL_BY_PIN = 1'b0,
        SEL_ALWAYS = 1'b1
    } sel_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] sreg;
        logic              loaded;
        logic [BYTE_W-1:0] hold;
        logic              hold_ok;
    } tx_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic edge_t find_edge(input logic now, input logic prev);
        edge_t e;
        e.rise = now & ~prev;
        e.fall = ~now & prev;
        return e;
    endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/spis_rx.sv
module spis_rx
    import spis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_clr,
    input  logic              bit_stb,
    input  logic              mosi_bit,
    input  logic              flag_clr,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              flag,
    output logic              byte_end,
    output logic              mid_byte
);
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-2:0] rx_sreg;

    assign byte_end = bit_stb && !cnt_clr && (bitcnt == LAST_BIT);
    assign mid_byte = (bitcnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            bitcnt  <= '0;
            rx_sreg <= '0;
            rx_byte <= '0;
        end else if (cnt_clr) begin
            bitcnt  <= '0;
        end else if (bit_stb) begin
            if (bitcnt == LAST_BIT) begin
                rx_byte <= {rx_sreg, mosi_bit};
                bitcnt  <= '0;
            end else begin
                rx_sreg <= {rx_sreg[BYTE_W-3:0], mosi_bit};
                bitcnt  <= bitcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (byte_end) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    a_r2_flag_after_last_bit: assert property (@(posedge clk) disable iff (rst)
        byte_end |=> flag);

    a_r8_count_holds: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr && !bit_stb) |=> $stable(bitcnt));

    a_r10_clear_zeroes_count: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (bitcnt == '0));
endmodule

// File: rtl/spis_tx.sv
module spis_tx
    import spis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              shift,
    input  logic              reload,
    output logic              miso_bit
);
    tx_state_t st, nx;

    always_comb begin
        nx = st;
        if (reload) begin
            if (st.hold_ok) begin
                nx.sreg    = st.hold;
                nx.loaded  = 1'b1;
                nx.hold_ok = 1'b0;
            end else begin
                nx.sreg   = '0;
                nx.loaded = 1'b0;
            end
        end else if (shift) begin
            nx.sreg = {st.sreg[BYTE_W-2:0], 1'b0};
        end
        if (wr) begin
            if (!nx.loaded) begin
                nx.sreg   = wdata;
                nx.loaded = 1'b1;
            end else begin
                nx.hold    = wdata;
                nx.hold_ok = 1'b1;
            end
        end
        if (!en) nx = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nx;
    end

    assign miso_bit = st.sreg[BYTE_W-1];

    a_r6_empty_sends_zero: assert property (@(posedge clk) disable iff (rst)
        !st.loaded |-> (st.sreg == '0));

    a_r5_hold_needs_loaded: assert property (@(posedge clk) disable iff (rst)
        st.hold_ok |-> st.loaded);

    a_r10_disable_empties: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!st.loaded && !st.hold_ok));
endmodule

// File: rtl/spi_slave_dbuf.sv
module spi_slave_dbuf
    import spis_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_three_wire,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              xfer_done,
    input  logic              xfer_done_clr,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_nss,
    output logic              spi_miso,
    output logic              spi_miso_oe
);
    logic [2:0] pins_s;
    logic       sck_s, mosi_s, nss_s;
    logic       sck_q, nss_q;
    edge_t      sck_e, nss_e;
    sel_mode_e  mode;
    logic       selected, active, cnt_clr, bit_stb, shift;
    logic       byte_end, mid_byte, miso_bit;

    spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({spi_nss, spi_mosi, spi_sck}),
        .d_out (pins_s)
    );

    assign {nss_s, mosi_s, sck_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            nss_q <= 1'b1;
        end else begin
            sck_q <= sck_s;
            nss_q <= nss_s;
        end
    end

    assign sck_e    = find_edge(sck_s, sck_q);
    assign nss_e    = find_edge(nss_s, nss_q);
    assign mode     = sel_mode_e'(cfg_three_wire);
    assign selected = (mode == SEL_ALWAYS) || !nss_s;
    assign active   = cfg_en && selected;
    assign cnt_clr  = !cfg_en || ((mode == SEL_BY_PIN) && nss_e.fall);
    assign bit_stb  = active && sck_e.rise;
    assign shift    = active && sck_e.fall && mid_byte;

    spis_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .cnt_clr  (cnt_clr),
        .bit_stb  (bit_stb),
        .mosi_bit (mosi_s),
        .flag_clr (xfer_done_clr),
        .rx_byte  (host_rdata),
        .flag     (xfer_done),
        .byte_end (byte_end),
        .mid_byte (mid_byte)
    );

    spis_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg_en),
        .wr       (host_wr),
        .wdata    (host_wdata),
        .shift    (shift),
        .reload   (byte_end),
        .miso_bit (miso_bit)
    );

    assign spi_miso_oe = active;
    assign spi_miso    = spi_miso_oe ? miso_bit : 1'bz;

    a_r7_deselected_no_capture: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && !cfg_three_wire && nss_s) |=> ($stable(host_rdata) && !$rose(xfer_done)));

    a_r10_disabled_no_capture: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(host_rdata));
endmodule

// File: tb/spi_slave_dbuf_tb.sv
module spi_slave_dbuf_tb;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_three_wire = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       xfer_done;
    logic       xfer_done_clr = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_nss = 1'b1;
    logic       spi_miso;
    logic       spi_miso_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit auto_clr = 1'b1;
    logic [7:0] exp_rx[$];

    always #5 clk = ~clk;

    spi_slave_dbuf u_dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_three_wire(cfg_three_wire),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .xfer_done(xfer_done), .xfer_done_clr(xfer_done_clr),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_nss(spi_nss),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    // Driver: clocks n bits of mo (MSB first) and collects MISO before each rising edge.
    task automatic xfer(input int n, input logic [7:0] mo, output logic [7:0] mi);
        mi = 8'h00;
        for (int i = 0; i < n; i++) begin
            spi_mosi = mo[7-i];
            idle(HALF);
            mi[7-i] = spi_miso;
            spi_sck = 1'b1;
            idle(HALF);
            spi_sck = 1'b0;
        end
        idle(HALF);
    endtask

    task automatic byte_check(input logic [7:0] mo, input logic [7:0] exp_miso, input string req);
        logic [7:0] got;
        exp_rx.push_back(mo);
        xfer(8, mo, got);
        chk(got == exp_miso, req, got, exp_miso);
    endtask

    // Monitor: pops expected received bytes when the completion flag rises.
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            xfer_done_clr <= 1'b0;
            if (!rst) begin
                if (xfer_done && !prev) begin
                    if (exp_rx.size() == 0) begin
                        chk(1'b0, "R1 unexpected byte", host_rdata, 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_rx.pop_front();
                        chk(host_rdata == e, "R1 rx byte", host_rdata, e);
                    end
                end
                if (xfer_done && auto_clr && !xfer_done_clr) xfer_done_clr <= 1'b1;
                prev = xfer_done;
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] junk;
        idle(3);
        rst = 1'b0;
        idle(2);
        // R11 reset state
        chk(host_rdata == 8'h00, "R11 rdata", host_rdata, 0);
        chk(xfer_done == 1'b0, "R11 flag", xfer_done, 0);
        chk(spi_miso_oe == 1'b0, "R11 oe", spi_miso_oe, 0);

        // 4-wire, nothing written: R1 capture, R6 zeros out
        cfg_en = 1'b1;
        spi_nss = 1'b0;
        idle(4);
        chk(spi_miso_oe == 1'b1, "R7 oe when selected", spi_miso_oe, 1);
        byte_check(8'hA5, 8'h00, "R6 empty sends zero");

        // R4 immediate load, R5 buffered value replaced, R3 MSB first
        host_write(8'h3C);
        host_write(8'h81);
        host_write(8'h5A);
        byte_check(8'h12, 8'h3C, "R4 immediate load");
        byte_check(8'hF0, 8'h5A, "R5 buffered replaced");
        byte_check(8'h0F, 8'h00, "R6 empty after drain");
        host_write(8'h96);
        byte_check(8'hC7, 8'h96, "R3 bit order");

        // R2 flag persists until cleared
        auto_clr = 1'b0;
        byte_check(8'h55, 8'h00, "R6 empty");
        idle(20);
        chk(xfer_done == 1'b1, "R2 flag held", xfer_done, 1);
        auto_clr = 1'b1;
        idle(4);
        chk(xfer_done == 1'b0, "R2 flag cleared", xfer_done, 0);

        // R7 deselected: no capture, output released
        spi_nss = 1'b1;
        idle(4);
        chk(spi_miso_oe == 1'b0, "R7 oe released", spi_miso_oe, 0);
        xfer(8, 8'hEE, junk);
        idle(4);
        chk(host_rdata == 8'h55, "R7 rdata kept", host_rdata, 8'h55);
        chk(xfer_done == 1'b0, "R7 no flag", xfer_done, 0);

        // R8 NSS falling edge drops a partial byte
        spi_nss = 1'b0;
        idle(4);
        xfer(3, 8'hE0, junk);
        spi_nss = 1'b1;
        idle(4);
        spi_nss = 1'b0;
        idle(4);
        byte_check(8'h6B, 8'h00, "R8 realigned");

        // R9 3-wire: NSS ignored
        cfg_three_wire = 1'b1;
        spi_nss = 1'b1;
        idle(4);
        chk(spi_miso_oe == 1'b1, "R9 oe in 3-wire", spi_miso_oe, 1);
        host_write(8'hC3);
        byte_check(8'h99, 8'hC3, "R9 transfer with nss high");
        exp_rx.push_back(8'hAD);
        xfer(3, 8'hA0, junk);
        spi_nss = 1'b0;
        idle(4);
        spi_nss = 1'b1;
        idle(4);
        xfer(5, 8'h68, junk);
        idle(4);
        chk(exp_rx.size() == 0, "R9 split byte joined", exp_rx.size(), 0);

        // R10 enable toggle resync, buffers emptied, writes dropped
        host_write(8'h11);
        host_write(8'h22);
        xfer(3, 8'hE0, junk);
        cfg_en = 1'b0;
        idle(4);
        chk(spi_miso_oe == 1'b0, "R10 oe off", spi_miso_oe, 0);
        host_write(8'h77);
        cfg_en = 1'b1;
        idle(4);
        byte_check(8'h42, 8'h00, "R10 emptied and realigned");

        idle(10);
        chk(exp_rx.size() == 0, "R1 all bytes seen", exp_rx.size(), 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule